// File: doc/BRIEF.md
# Dual Speculative/Architectural Predicate File

This block holds a file of 64 one-bit predicates in two copies. The speculative copy takes each predicate result in the cycle the compare produces it. Every consumer reads that copy through its own index-selected read port. Because the copy already holds every in-flight result, consumers need no forwarding path. The architectural copy changes only when the predicate-writing instruction retires.

Each copy has its own bank of single-bit write ports and its own whole-file broadside write. Both copies are always visible as 64-bit broadside read vectors. On a flush or exception, the speculative copy is overwritten from the architectural copy in one cycle, which discards every mispeculated write.

Entry 0 is the constant-true predicate. The compare units and the retirement logic are outside the block. They appear only as the write request ports.

Top module: `pred_dual_file`

## Requirements
- R1: After reset, both copies hold 64'h0000_0000_0000_0001: entry 0 is 1 and every other entry is 0.
- R2: Entry 0 reads as 1 on every read port and in both broadside vectors. Any single-bit or broadside write of 0 to entry 0 is ignored.
- R3: There are 15 read ports. Port k takes its 6-bit index from rd_idx_i[6k+5:6k] and returns the current speculative value of that entry on rd_val_o[k], with no delay. A speculative write takes effect at the next clock edge. After that edge it is visible on the read ports and on spec_vec_o.
- R4: There are 11 speculative write ports. Port k is enabled by spec_wr_en_i[k], takes its index from spec_wr_idx_i[6k+5:6k] and its value from spec_wr_val_i[k]. When several enabled ports target the same entry in one cycle, the highest-numbered port decides the value. Entries that no port targets keep their value.
- R5: A speculative broadside write (spec_bs_we_i) replaces entries 63..1 with spec_bs_data_i[63:1]. It takes priority over all speculative single-bit writes in the same cycle.
- R6: The architectural copy changes only through the retire ports. Speculative writes of any kind leave arch_vec_o unchanged.
- R7: The 11 retire write ports and the retire broadside write update the architectural copy. They use the same index layout, the same higher-port-wins rule and the same broadside priority as R4 and R5.
- R8: When flush_i is high at a clock edge, the speculative copy becomes equal to the architectural copy as updated at that same edge, including that cycle's retire writes. All speculative writes presented in that cycle are dropped.
- R9: spec_vec_o and arch_vec_o continuously present the full contents of the speculative and architectural copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Restore the speculative copy from the architectural copy |
| spec_wr_en_i | input | 11 | Speculative single-bit write enables |
| spec_wr_idx_i | input | 66 | Speculative write indices, 6 bits per port |
| spec_wr_val_i | input | 11 | Speculative write values |
| spec_bs_we_i | input | 1 | Speculative broadside write enable |
| spec_bs_data_i | input | 64 | Speculative broadside write data |
| ret_wr_en_i | input | 11 | Retire single-bit write enables |
| ret_wr_idx_i | input | 66 | Retire write indices, 6 bits per port |
| ret_wr_val_i | input | 11 | Retire write values |
| ret_bs_we_i | input | 1 | Retire broadside write enable |
| ret_bs_data_i | input | 64 | Retire broadside write data |
| rd_idx_i | input | 90 | Read port indices, 6 bits per port |
| rd_val_o | output | 15 | Read port values from the speculative copy |
| spec_vec_o | output | 64 | Broadside read of the speculative copy |
| arch_vec_o | output | 64 | Broadside read of the architectural copy |

## Verification
The assertions check four things on every cycle: entry 0 stays set in both copies, the copies agree right after a flush, each copy stays unchanged in cycles with no write to it, and a speculative broadside write lands in full. Only the bench's scenarios can show the following: the value chosen when ports collide on one entry, that the read ports select the right entry, the exact mix of retire updates that a flush copies over, and the accumulated contents of both copies across long random sequences of mixed writes and flushes. These are compared against a bench model of both copies.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned NUM_PRED    = 64;
  localparam int unsigned PRED_IDX_W  = $clog2(NUM_PRED);
  localparam int unsigned NUM_RD      = 15;
  localparam int unsigned NUM_SPEC_WR = 11;
  localparam int unsigned NUM_RET_WR  = 11;
endpackage

// File: rtl/pred_idx_dec.sv
module pred_idx_dec #(
  parameter int unsigned N_ENT = 64,
  parameter int unsigned IDX_W = 6
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N_ENT-1:0] hot_o
);
  always_comb begin
    hot_o = '0;
    if (en_i) hot_o[idx_i] = 1'b1;
  end
endmodule

// File: rtl/pred_wr_merge.sv
module pred_wr_merge #(
  parameter int unsigned N_ENT = 64,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned N_WR  = 11
) (
  input  logic [N_ENT-1:0]      cur_i,
  input  logic [N_WR-1:0]       wr_en_i,
  input  logic [N_WR*IDX_W-1:0] wr_idx_i,
  input  logic [N_WR-1:0]       wr_val_i,
  input  logic                  bs_we_i,
  input  logic [N_ENT-1:0]      bs_data_i,
  output logic [N_ENT-1:0]      nxt_o
);
  logic [N_WR:0][N_ENT-1:0] stage;
  logic [N_ENT-1:0]         merged;

  assign stage[0] = cur_i;

  // AND-OR chain; later (higher) ports overwrite earlier ones
  for (genvar p = 0; p < N_WR; p++) begin : g_port
    logic [N_ENT-1:0] hot;
    pred_idx_dec #(.N_ENT(N_ENT), .IDX_W(IDX_W)) i_dec (
      .en_i  (wr_en_i[p]),
      .idx_i (wr_idx_i[p*IDX_W +: IDX_W]),
      .hot_o (hot)
    );
    assign stage[p+1] = (stage[p] & ~hot) | (hot & {N_ENT{wr_val_i[p]}});
  end

  assign merged = bs_we_i ? bs_data_i : stage[N_WR];
  // entry 0 is hard-wired true
  assign nxt_o  = merged | {{(N_ENT-1){1'b0}}, 1'b1};
endmodule

// File: rtl/pred_rd_mux.sv
module pred_rd_mux #(
  parameter int unsigned N_ENT = 64,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned N_RD  = 15
) (
  input  logic [N_ENT-1:0]      vec_i,
  input  logic [N_RD*IDX_W-1:0] idx_i,
  output logic [N_RD-1:0]       val_o
);
  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign val_o[r] = vec_i[idx_i[r*IDX_W +: IDX_W]];
  end
endmodule

// File: rtl/pred_dual_file.sv
module pred_dual_file
  import pred_pkg::*;
#(
  parameter int unsigned N_ENT   = NUM_PRED,
  parameter int unsigned N_RD    = NUM_RD,
  parameter int unsigned N_SWR   = NUM_SPEC_WR,
  parameter int unsigned N_RWR   = NUM_RET_WR,
  localparam int unsigned IDX_W  = $clog2(N_ENT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic [N_SWR-1:0]       spec_wr_en_i,
  input  logic [N_SWR*IDX_W-1:0] spec_wr_idx_i,
  input  logic [N_SWR-1:0]       spec_wr_val_i,
  input  logic                   spec_bs_we_i,
  input  logic [N_ENT-1:0]       spec_bs_data_i,
  input  logic [N_RWR-1:0]       ret_wr_en_i,
  input  logic [N_RWR*IDX_W-1:0] ret_wr_idx_i,
  input  logic [N_RWR-1:0]       ret_wr_val_i,
  input  logic                   ret_bs_we_i,
  input  logic [N_ENT-1:0]       ret_bs_data_i,
  input  logic [N_RD*IDX_W-1:0]  rd_idx_i,
  output logic [N_RD-1:0]        rd_val_o,
  output logic [N_ENT-1:0]       spec_vec_o,
  output logic [N_ENT-1:0]       arch_vec_o
);
  localparam logic [N_ENT-1:0] RST_VEC = {{(N_ENT-1){1'b0}}, 1'b1};

  logic [N_ENT-1:0] spec_q, spec_d;
  logic [N_ENT-1:0] arch_q, arch_d;

  pred_wr_merge #(.N_ENT(N_ENT), .IDX_W(IDX_W), .N_WR(N_SWR)) i_spec_merge (
    .cur_i     (spec_q),
    .wr_en_i   (spec_wr_en_i),
    .wr_idx_i  (spec_wr_idx_i),
    .wr_val_i  (spec_wr_val_i),
    .bs_we_i   (spec_bs_we_i),
    .bs_data_i (spec_bs_data_i),
    .nxt_o     (spec_d)
  );

  pred_wr_merge #(.N_ENT(N_ENT), .IDX_W(IDX_W), .N_WR(N_RWR)) i_arch_merge (
    .cur_i     (arch_q),
    .wr_en_i   (ret_wr_en_i),
    .wr_idx_i  (ret_wr_idx_i),
    .wr_val_i  (ret_wr_val_i),
    .bs_we_i   (ret_bs_we_i),
    .bs_data_i (ret_bs_data_i),
    .nxt_o     (arch_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arch_q <= RST_VEC;
      spec_q <= RST_VEC;
    end else begin
      arch_q <= arch_d;
      // restore includes this cycle's retirements; speculative writes dropped
      spec_q <= flush_i ? arch_d : spec_d;
    end
  end

  pred_rd_mux #(.N_ENT(N_ENT), .IDX_W(IDX_W), .N_RD(N_RD)) i_rd_mux (
    .vec_i (spec_q),
    .idx_i (rd_idx_i),
    .val_o (rd_val_o)
  );

  assign spec_vec_o = spec_q;
  assign arch_vec_o = arch_q;

  AST_P0_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_q[0] && arch_q[0]); // R2

  AST_FLUSH_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (spec_q == arch_q)); // R8

  AST_ARCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|ret_wr_en_i) && !ret_bs_we_i) |=> $stable(arch_q)); // R6

  AST_SPEC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|spec_wr_en_i) && !spec_bs_we_i && !flush_i) |=> $stable(spec_q)); // R3

  AST_SPEC_BS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec_bs_we_i && !flush_i) |=> (spec_q[N_ENT-1:1] == $past(spec_bs_data_i[N_ENT-1:1]))); // R5
endmodule

// File: tb/test_pred_dual_file.sv
`timescale 1ns/1ps
module test_pred_dual_file;
  localparam int NE = 64;
  localparam int IW = 6;
  localparam int NR = 15;
  localparam int NW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush;
  logic [NW-1:0]    s_en, r_en, s_val, r_val;
  logic [NW*IW-1:0] s_idx, r_idx;
  logic             s_bw, r_bw;
  logic [NE-1:0]    s_bd, r_bd;
  logic [NR*IW-1:0] rd_idx;
  logic [NR-1:0]    rd_val;
  logic [NE-1:0]    spec_vec, arch_vec;

  logic [NE-1:0] spec_m, arch_m;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pred_dual_file i_pred_dual_file (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .spec_wr_en_i(s_en), .spec_wr_idx_i(s_idx), .spec_wr_val_i(s_val),
    .spec_bs_we_i(s_bw), .spec_bs_data_i(s_bd),
    .ret_wr_en_i(r_en), .ret_wr_idx_i(r_idx), .ret_wr_val_i(r_val),
    .ret_bs_we_i(r_bw), .ret_bs_data_i(r_bd),
    .rd_idx_i(rd_idx), .rd_val_o(rd_val),
    .spec_vec_o(spec_vec), .arch_vec_o(arch_vec)
  );

  function automatic logic [NE-1:0] apply_wr(
    input logic [NE-1:0] v, input logic [NW-1:0] en,
    input logic [NW*IW-1:0] idx, input logic [NW-1:0] val,
    input logic bw, input logic [NE-1:0] bd);
    logic [NE-1:0] r = v;
    for (int p = 0; p < NW; p++)
      if (en[p]) r[idx[p*IW +: IW]] = val[p];
    if (bw) r = bd;
    r[0] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [NE-1:0] act, input logic [NE-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    flush = 0; s_en = '0; r_en = '0; s_val = '0; r_val = '0;
    s_idx = '0; r_idx = '0; s_bw = 0; r_bw = 0; s_bd = '0; r_bd = '0;
  endtask

  task automatic set_port(input bit spec, input int p, input int idx, input bit v);
    if (spec) begin s_en[p] = 1; s_idx[p*IW +: IW] = IW'(idx); s_val[p] = v; end
    else      begin r_en[p] = 1; r_idx[p*IW +: IW] = IW'(idx); r_val[p] = v; end
  endtask

  // inputs already driven (at a negedge); advance one edge and check all outputs
  task automatic step(input string tag);
    arch_m = apply_wr(arch_m, r_en, r_idx, r_val, r_bw, r_bd);
    spec_m = flush ? arch_m : apply_wr(spec_m, s_en, s_idx, s_val, s_bw, s_bd);
    @(negedge clk);
    chk({tag, " spec R9"}, spec_vec, spec_m);
    chk({tag, " arch R6"}, arch_vec, arch_m);
    for (int k = 0; k < NR; k++)
      chk({tag, " read R3"}, NE'(rd_val[k]), NE'(spec_m[rd_idx[k*IW +: IW]]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle_inputs();
    for (int k = 0; k < NR; k++) rd_idx[k*IW +: IW] = IW'(k * 4);
    repeat (3) @(negedge clk);
    rst_n = 1;
    spec_m = 64'h1; arch_m = 64'h1;
    chk("R1 reset spec", spec_vec, 64'h1);
    chk("R1 reset arch", arch_vec, 64'h1);
    chk("R2 entry0 read", NE'(rd_val[0]), 64'd1);

    // R4: ports 3 and 7 collide on entry 5, port 7 wins; R2: write 0 to entry 0
    set_port(1, 3, 5, 1); set_port(1, 7, 5, 0);
    set_port(1, 2, 9, 1); set_port(1, 0, 0, 0);
    set_port(1, 9, 12, 1); set_port(1, 4, 12, 0);
    step("R4");
    chk("R4 collision higher port wins", NE'({spec_vec[12], spec_vec[9], spec_vec[5]}), NE'(3'b110));
    chk("R2 entry0 write ignored", NE'(spec_vec[0]), 64'd1);
    chk("R6 arch untouched by spec", arch_vec, 64'h1);
    idle_inputs();

    // R5: broadside beats single writes
    s_bw = 1; s_bd = 64'hA5A5_0F0F_3C3C_FFFE; set_port(1, 10, 20, 0);
    step("R5");
    chk("R5 broadside priority", spec_vec, 64'hA5A5_0F0F_3C3C_FFFF);
    idle_inputs();

    // R7: retire collisions and broadside
    set_port(0, 1, 33, 1); set_port(0, 6, 33, 0); set_port(0, 8, 40, 1);
    step("R7");
    chk("R7 retire collision", NE'({arch_vec[40], arch_vec[33]}), NE'(2'b10));
    idle_inputs();
    r_bw = 1; r_bd = 64'h0123_4567_89AB_CDEE; set_port(0, 10, 3, 0);
    step("R7b");
    chk("R7 retire broadside", arch_vec, 64'h0123_4567_89AB_CDEF);
    idle_inputs();

    // R8: flush with same-cycle spec writes and retire write
    set_port(1, 0, 50, 1); s_bw = 1; s_bd = '1; set_port(0, 5, 50, 0); set_port(0, 2, 61, 1);
    flush = 1;
    step("R8");
    chk("R8 flush restores arch", spec_vec, arch_vec);
    chk("R8 flush value", spec_vec, (64'h0123_4567_89AB_CDEF & ~(64'd1 << 50)) | (64'd1 << 61));
    idle_inputs();

    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < NW; p++) begin
        if ($urandom_range(3) == 0) set_port(1, p, $urandom_range(63), 1'($urandom));
        if ($urandom_range(3) == 0) set_port(0, p, $urandom_range(63), 1'($urandom));
      end
      s_bw = ($urandom_range(31) == 0); s_bd = {$urandom, $urandom};
      r_bw = ($urandom_range(31) == 0); r_bd = {$urandom, $urandom};
      flush = ($urandom_range(15) == 0);
      for (int k = 0; k < NR; k++) rd_idx[k*IW +: IW] = IW'($urandom_range(63));
      step("rand");
      idle_inputs();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule